// File: doc/BRIEF.md
# Shared-Timebase Four-Channel PWM Generator

This block drives a group of pulse-width-modulated outputs from one common timebase. A single up-counter, fed through a clock prescaler, counts from zero to a programmable period limit and wraps. Each channel compares that count against its own threshold and holds its output active while the count is below the threshold. Each channel also has a polarity control, an enable for its main output, and an enable for a complementary output. A single output gate forces every pin to its idle level.

Software loads settings through a simple write port with an address and a data word. The prescaler and every threshold are buffered. A buffered value reaches the datapath only on an update event. An update event is either the counter wrapping or a write that forces an update. The period limit is buffered the same way when the preload bit is set, and applies at once when it is clear.

The counter is run by a two-state machine with the states STOP and RUN. A control write with the run bit set takes STOP to RUN (transition START). A control write with the run bit clear takes RUN to STOP (transition HALT). In STOP the counter and the prescaler counter hold their values. A forced update still restarts both of them from zero in either state.

Top module: `pwm_quad_gen`

## Requirements
- R1: After reset every main and complementary output is 0, the counter is in STOP, and all settings are 0.
- R2: In RUN the counter advances once every (divider+1) clocks, where divider is the value at address 1, and wraps to 0 after reaching the period value at address 2. One PWM period therefore lasts (divider+1)*(period+1) clocks.
- R3: A channel's reference signal is active while the count is below that channel's threshold. Threshold 0 is never active, and a threshold above the period value is always active. The thresholds are written at addresses 4+c.
- R4: A written threshold, and a written divider, has no effect until the next update event.
- R5: Control bit 1 selects preload. When it is 1, a new period value applies at the next update event. When it is 0, the new value applies on the clock after the write.
- R6: A control write (address 0) with bit 3 set is an update event at that clock edge. It loads all buffered values and sets the counter and prescaler counter to 0, in both STOP and RUN. A counter wrap is also an update event.
- R7: Control bit 0 selects RUN (1) or STOP (0). In STOP the count does not change except through a forced update.
- R8: The polarity bit of a channel inverts both its main and its complementary output.
- R9: With both of a channel's enables set and the gate open, the complementary output is the inverse of the main output.
- R10: A disabled output, or any output while the gate (control bit 2) is 0, sits at its idle level, which equals the channel's polarity bit.
- R11: The channel configuration word at address 3 holds 4 bits per channel, starting at bit 4c: bit 4c is the main enable, bit 4c+1 is the polarity, bit 4c+2 is the complementary enable, and bit 4c+3 is unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW (3) | Register address: 0 control, 1 divider, 2 period, 3 channel config, 4..7 thresholds |
| wr_data | input | CNT_W (16) | Write data |
| pwm_o | output | NUM_CH (4) | Main outputs |
| pwm_n_o | output | NUM_CH (4) | Complementary outputs |

## Verification
The outputs are combinational from registers. A change caused by a write therefore appears right after the clock edge that takes the write, and the bench samples it at the next falling edge. After a forced update at edge E, the count is 0 through the first (divider+1) falling-edge samples. One full period therefore spans exactly (divider+1)*(period+1) samples starting at the first falling edge after E. The bench counts active samples over that window and compares the total against the formula. For the period-buffering tests the bench predicts the count of every sample after the write. A buffered period appears only after the current period ends, while an unbuffered one shortens the current period. Each output is checked against that prediction one sample at a time.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
    typedef enum logic {TB_STOP = 1'b0, TB_RUN = 1'b1} tb_state_e;

    // register addresses
    localparam int ADR_CTRL  = 0;
    localparam int ADR_PSC   = 1;
    localparam int ADR_PER   = 2;
    localparam int ADR_CHCFG = 3;
    localparam int ADR_CMP0  = 4;

    // control word bits
    localparam int CB_RUN   = 0;
    localparam int CB_PRE   = 1;
    localparam int CB_MOE   = 2;
    localparam int CB_FORCE = 3;

    // per-channel config field layout
    localparam int CF_EN     = 0;
    localparam int CF_POL    = 1;
    localparam int CF_CEN    = 2;
    localparam int CF_STRIDE = 4;
endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_run,
    input  logic             force_upd,
    input  logic             arpe,
    input  logic [CNT_W-1:0] psc_pre,
    input  logic [CNT_W-1:0] arr_pre,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] pcnt,
    output logic             ue,
    output logic             running
);
    tb_state_e        st_q, st_d;
    logic [CNT_W-1:0] psc_sh, arr_sh, arr_eff;
    logic             tick, wrap;

    // next-state: START on run write, HALT on stop write
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TB_STOP: if (ctl_wr && ctl_run)  st_d = TB_RUN;
            TB_RUN:  if (ctl_wr && !ctl_run) st_d = TB_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TB_STOP;
        else        st_q <= st_d;
    end

    // outputs of the state machine
    always_comb begin
        running = (st_q == TB_RUN);
        arr_eff = arpe ? arr_sh : arr_pre;
        tick    = running && (pcnt >= psc_sh);
        wrap    = tick && (cnt >= arr_eff);
        ue      = force_upd || wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
            cnt  <= '0;
        end else if (force_upd) begin
            pcnt <= '0;
            cnt  <= '0;
        end else if (tick) begin
            pcnt <= '0;
            cnt  <= wrap ? '0 : cnt + 1'b1;
        end else if (running) begin
            pcnt <= pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_sh <= '0;
            arr_sh <= '0;
        end else if (ue) begin
            psc_sh <= psc_pre;
            arr_sh <= arr_pre;
        end
    end
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             ue,
    input  logic [CNT_W-1:0] cnt,
    input  logic             moe,
    input  logic             en,
    input  logic             pol,
    input  logic             cen,
    output logic             out,
    output logic             outn,
    output logic [CNT_W-1:0] cmp_act
);
    logic [CNT_W-1:0] cmp_pre;
    logic             ref_act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_pre <= '0;
            cmp_act <= '0;
        end else begin
            if (cmp_wr) cmp_pre <= cmp_wdata;
            if (ue)     cmp_act <= cmp_pre;
        end
    end

    always_comb begin
        ref_act = (cnt < cmp_act);
        out     = pol ^ (moe & en  &  ref_act);
        outn    = pol ^ (moe & cen & ~ref_act);
    end
endmodule

// File: rtl/pwm_quad_gen.sv
`timescale 1ns/1ps
module pwm_quad_gen
    import pwm_pkg::*;
#(
    parameter  int NUM_CH = 4,
    parameter  int CNT_W  = 16,
    localparam int AW     = $clog2(ADR_CMP0 + NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] pwm_o,
    output logic [NUM_CH-1:0] pwm_n_o
);
    logic                         ctl_wr, force_upd, arpe_q, moe_q;
    logic [CNT_W-1:0]             psc_pre_q, arr_pre_q, cnt, pcnt;
    logic                         ue, running;
    logic [NUM_CH-1:0]            en_q, pol_q, cen_q;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;

    assign ctl_wr    = wr_en && (wr_addr == AW'(ADR_CTRL));
    assign force_upd = ctl_wr && wr_data[CB_FORCE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arpe_q    <= 1'b0;
            moe_q     <= 1'b0;
            psc_pre_q <= '0;
            arr_pre_q <= '0;
            en_q      <= '0;
            pol_q     <= '0;
            cen_q     <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(ADR_CTRL)) begin
                arpe_q <= wr_data[CB_PRE];
                moe_q  <= wr_data[CB_MOE];
            end
            if (wr_addr == AW'(ADR_PSC)) psc_pre_q <= wr_data;
            if (wr_addr == AW'(ADR_PER)) arr_pre_q <= wr_data;
            if (wr_addr == AW'(ADR_CHCFG)) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    en_q[c]  <= wr_data[c*CF_STRIDE + CF_EN];
                    pol_q[c] <= wr_data[c*CF_STRIDE + CF_POL];
                    cen_q[c] <= wr_data[c*CF_STRIDE + CF_CEN];
                end
            end
        end
    end

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_run   (wr_data[CB_RUN]),
        .force_upd (force_upd),
        .arpe      (arpe_q),
        .psc_pre   (psc_pre_q),
        .arr_pre   (arr_pre_q),
        .cnt       (cnt),
        .pcnt      (pcnt),
        .ue        (ue),
        .running   (running)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic cmp_wr;
        assign cmp_wr = wr_en && (wr_addr == AW'(ADR_CMP0 + g));
        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmp_wr    (cmp_wr),
            .cmp_wdata (wr_data),
            .ue        (ue),
            .cnt       (cnt),
            .moe       (moe_q),
            .en        (en_q[g]),
            .pol       (pol_q[g]),
            .cen       (cen_q[g]),
            .out       (pwm_o[g]),
            .outn      (pwm_n_o[g]),
            .cmp_act   (cmp_act[g])
        );
    end
endmodule

// File: rtl/pwm_quad_gen_chk.sv
`timescale 1ns/1ps
module pwm_quad_gen_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [CNT_W-1:0]             cnt,
    input logic [CNT_W-1:0]             pcnt,
    input logic                         running,
    input logic                         force_upd,
    input logic                         ue,
    input logic                         moe,
    input logic [NUM_CH-1:0]            en,
    input logic [NUM_CH-1:0]            pol,
    input logic [NUM_CH-1:0]            cen,
    input logic [NUM_CH-1:0][CNT_W-1:0] cmp_act,
    input logic [NUM_CH-1:0]            pwm_o,
    input logic [NUM_CH-1:0]            pwm_n_o
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> (cnt == $past(cnt) + 1'b1) || (cnt == '0));

    // R6
    force_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> (cnt == '0) && (pcnt == '0));

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !force_upd) |=> $stable(cnt));

    // R4
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_act) |-> $past(ue));

    // R10
    gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !moe |-> (pwm_o == pol) && (pwm_n_o == pol));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_pair
        // R9
        comp_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (moe && en[g] && cen[g]) |-> (pwm_o[g] != pwm_n_o[g]));
    end
endmodule

bind pwm_quad_gen pwm_quad_gen_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt),
    .pcnt      (pcnt),
    .running   (running),
    .force_upd (force_upd),
    .ue        (ue),
    .moe       (moe_q),
    .en        (en_q),
    .pol       (pol_q),
    .cen       (cen_q),
    .cmp_act   (cmp_act),
    .pwm_o     (pwm_o),
    .pwm_n_o   (pwm_n_o)
);

// File: tb/sim_pwm_quad_gen.sv
`timescale 1ns/1ps
module sim_pwm_quad_gen;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [NCH-1:0] pwm_o, pwm_n_o;

    int total = 0;
    int bad   = 0;
    int hi [NCH];
    int hin[NCH];

    // stimulus / expected table: divider, period, threshold ch0, polarity, expected ch0 high count
    localparam int NV = 5;
    localparam int VP  [NV] = '{0, 1, 2, 0, 3};
    localparam int VA  [NV] = '{9, 7, 4, 5, 6};
    localparam int VC  [NV] = '{3, 5, 0, 6, 2};
    localparam int VPOL[NV] = '{0, 0, 0, 0, 1};
    localparam int VHI0[NV] = '{3, 10, 0, 6, 20};

    pwm_quad_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_o(pwm_o), .pwm_n_o(pwm_n_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(a);
        wr_data = 16'(d);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic measure(input int n);
        for (int c = 0; c < NCH; c++) begin hi[c] = 0; hin[c] = 0; end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                hi[c]  += int'(pwm_o[c]);
                hin[c] += int'(pwm_n_o[c]);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 main outputs in reset", int'(pwm_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 main outputs after reset", int'(pwm_o), 0);
        check("R1 complementary outputs after reset", int'(pwm_n_o), 0);

        // table-driven vectors: R2 R3 R8 R9
        for (int v = 0; v < NV; v++) begin
            int per, base, eo, en;
            wr(3, VPOL[v] != 0 ? 16'h7777 : 16'h5555);
            wr(1, VP[v]);
            wr(2, VA[v]);
            for (int c = 0; c < NCH; c++) wr(4 + c, VC[v] + c);
            wr(0, 16'hF);
            per = (VP[v] + 1) * (VA[v] + 1);
            measure(per);
            for (int c = 0; c < NCH; c++) begin
                base = (VP[v] + 1) * ((VC[v] + c) < (VA[v] + 1) ? (VC[v] + c) : (VA[v] + 1));
                eo = (VPOL[v] != 0) ? per - base : base;
                en = (VPOL[v] != 0) ? base : per - base;
                if (c == 0) eo = VHI0[v];
                check($sformatf("R2 R3 R8 vec%0d ch%0d main high", v, c), hi[c], eo);
                check($sformatf("R9 R8 vec%0d ch%0d compl high", v, c), hin[c], en);
            end
        end

        // R5 buffered period: old length finishes first
        wr(3, 16'h5555);
        wr(1, 0);
        wr(2, 9);
        wr(4, 2);
        wr(0, 16'hF);
        wr(2, 3);
        for (int k = 1; k <= 14; k++) begin
            int ec;
            @(negedge clk);
            ec = (k <= 9) ? k : (k - 10) % 4;
            check($sformatf("R5 preload on sample %0d", k), int'(pwm_o[0]), int'(ec < 2));
        end
        // R5 unbuffered period: applies at once
        wr(2, 9);
        wr(0, 16'hD);
        wr(2, 3);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            check($sformatf("R5 preload off sample %0d", k), int'(pwm_o[0]), int'((k % 4) < 2));
        end

        // R6 R7 R4 forced update while stopped
        wr(0, 16'h6);
        wr(1, 0);
        wr(2, 9);
        wr(4, 4);
        wr(0, 16'hE);
        measure(5);
        check("R7 R6 stopped after force, held active", hi[0], 5);
        wr(4, 0);
        @(negedge clk);
        check("R4 threshold write without update ignored", int'(pwm_o[0]), 1);
        wr(0, 16'hE);
        @(negedge clk);
        check("R6 forced update in STOP loads threshold", int'(pwm_o[0]), 0);

        // R10 gate closed and disabled outputs sit at polarity level
        wr(3, 16'h7777);
        wr(0, 16'h3);
        measure(10);
        check("R10 gate closed main idle", hi[0] + hi[1] + hi[2] + hi[3], 40);
        check("R10 gate closed compl idle", hin[0] + hin[1] + hin[2] + hin[3], 40);
        wr(3, 16'h0000);
        wr(0, 16'h7);
        measure(10);
        check("R10 disabled no polarity", hi[0] + hin[0] + hi[3] + hin[3], 0);
        wr(3, 16'h2222);
        measure(10);
        check("R10 disabled with polarity", hi[1] + hin[1] + hi[2] + hin[2], 40);

        // R11 field positions: only channel 2 enabled (bits 8 and 10)
        wr(3, 16'h0500);
        wr(1, 0);
        wr(2, 7);
        wr(6, 3);
        wr(0, 16'hF);
        measure(8);
        check("R11 ch2 main high", hi[2], 3);
        check("R11 ch2 compl high", hin[2], 5);
        check("R11 other channels idle", hi[0] + hin[0] + hi[1] + hin[1] + hi[3] + hin[3], 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule